// File: doc/BRIEF.md
# Priority-Selected Converter Clock Prescaler

This block derives the conversion clock of an on-chip converter from the system clock. Software programs one 8-bit control register over a byte-wide register bus. Four request bits in that register each ask for a division: by 2, by 4, by 8 or by 16. When more than one bit is set, a fixed priority decides which division applies, and the largest requested divisor always wins. When no bit is set, the block passes the system clock through undivided.

The output is a clock-enable, `conv_en`. It is held high in pass-through mode. In divided mode it is a single-cycle pulse once per division period. A free-running counter produces the pulses. A new ratio waits for the end of the current period, so no period is ever cut short. The ratio in force is also reported as a small status code plus a separate divide-by-16 flag.

Top module: `cnvclk_prescaler`

## Requirements
- R1: The control register answers at register address 0xF76 only. A write with `bus_sel`=1 and `bus_wr`=1 at that address stores the data. A read (`bus_sel`=1, `bus_wr`=0) at that address returns the register on `bus_rdata` in the same cycle. Any other address reads as 0x00 and is not written.
- R2: Bits 7..4 of the register are reserved. Write data in those bits is discarded, and they always read back as 0.
- R3: After reset the register holds 0x00. The block is then in pass-through mode: `conv_en`=1, `ratio_code`=0 and `ratio_div16`=0.
- R4: While the ratio in force is divide-by-1, `conv_en` is high on every system clock.
- R5: Request bit k (bit 0 = /2, bit 1 = /4, bit 2 = /8, bit 3 = /16) asks for divisor 2^(k+1). Among the set bits, the highest-numbered one alone selects the divisor. For example, 0b0101 gives /8. With no bit set the divisor is 1.
- R6: In divide-by-N mode, `conv_en` is a one-cycle pulse repeating exactly every N system clocks.
- R7: A new request is adopted only in a cycle where `conv_en` is high, which is the last cycle of a period. From pass-through this is the next clock, since `conv_en` is high on every cycle.
- R8: The status outputs reflect the ratio in force. `ratio_code` is 0 for /1, 1 for /2, 2 for /4 and 3 for /8. `ratio_div16`=1 with `ratio_code`=0 means /16.
- R9: The first period under a newly adopted ratio is full length. Its first pulse comes N clocks after the last pulse of the old ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not selected |
| conv_en | output | 1 | Converter clock-enable |
| ratio_code | output | 2 | Ratio in force: 0 = /1, 1 = /2, 2 = /4, 3 = /8 |
| ratio_div16 | output | 1 | Ratio in force is /16 |

## Verification
A register write and the terminal count of the divider can land on the same clock edge. In that case the divider must adopt the request held before the write, and take up the new value one full period later.

The bench sweeps every pair of the 16 request settings. The second write is placed at a phase offset that varies with the pair, so many writes fall exactly on the terminal-count edge. An independent cycle model tracks the divisor and the period phase. Every cycle, `conv_en` and the status outputs are judged against that model.

// File: rtl/cnvclk_pkg.sv
package cnvclk_pkg;
  localparam int REQ_BITS = 4;
  localparam int SHIFT_W  = 3;
  localparam int CNT_W    = 4;

  typedef logic [SHIFT_W-1:0] shift_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  // log2 of the divisor chosen by the highest set request bit
  function automatic shift_t prio_shift(input logic [REQ_BITS-1:0] req);
    shift_t s;
    s = '0;
    for (int i = 0; i < REQ_BITS; i++) begin
      if (req[i]) s = shift_t'(i + 1);
    end
    return s;
  endfunction

  // last counter value of a period of 2**s clocks
  function automatic cnt_t period_last(input shift_t s);
    logic [CNT_W:0] one_hot;
    one_hot = (CNT_W+1)'(1) << s;
    return cnt_t'(one_hot - 1'b1);
  endfunction

  function automatic logic [1:0] status_code(input shift_t s);
    return (s >= shift_t'(REQ_BITS)) ? 2'd0 : s[1:0];
  endfunction
endpackage

// File: rtl/cnvclk_ctrl_reg.sv
module cnvclk_ctrl_reg #(
  parameter int              ADDR_W   = 12,
  parameter int              DATA_W   = 8,
  parameter int              REQ_BITS = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'hF76
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [REQ_BITS-1:0] req_q,
  output logic                wr_hit
);
  localparam int RSV_W = DATA_W - REQ_BITS;

  logic hit;
  assign hit    = bus_sel && (bus_addr == REG_ADDR);
  assign wr_hit = hit && bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)      req_q <= '0;
    else if (wr_hit) req_q <= bus_wdata[REQ_BITS-1:0];
  end

  assign bus_rdata = (hit && !bus_wr) ? {{RSV_W{1'b0}}, req_q} : '0;
endmodule

// File: rtl/cnvclk_prio_sel.sv
module cnvclk_prio_sel
  import cnvclk_pkg::*;
#(
  parameter int NREQ = REQ_BITS
) (
  input  logic [NREQ-1:0] req,
  output shift_t          req_shift
);
  logic [NREQ-1:0] win;

  for (genvar gi = 0; gi < NREQ; gi++) begin : g_win
    if (gi == NREQ - 1) begin : g_top
      assign win[gi] = req[gi];
    end else begin : g_low
      assign win[gi] = req[gi] & ~(|req[NREQ-1:gi+1]);
    end
  end

  always_comb begin
    req_shift = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (win[i]) req_shift = shift_t'(i + 1);
    end
  end
endmodule

// File: rtl/cnvclk_div_core.sv
module cnvclk_div_core
  import cnvclk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  shift_t req_shift,
  output shift_t act_shift,
  output cnt_t   cnt,
  output logic   tc,
  output logic   conv_en
);
  cnt_t last_val;
  assign last_val = period_last(act_shift);
  assign tc       = (cnt == last_val);
  assign conv_en  = tc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_shift <= '0;
    end else if (tc) begin
      cnt       <= '0;
      act_shift <= req_shift;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cnvclk_prescaler.sv
module cnvclk_prescaler
  import cnvclk_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'hF76
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              conv_en,
  output logic [1:0]        ratio_code,
  output logic              ratio_div16
);
  logic [REQ_BITS-1:0] req_q;
  logic                wr_hit;
  shift_t              req_shift;
  shift_t              act_shift;
  cnt_t                cnt;
  logic                tc;

  cnvclk_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REQ_BITS(REQ_BITS), .REG_ADDR(REG_ADDR)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_q(req_q), .wr_hit(wr_hit)
  );

  cnvclk_prio_sel #(.NREQ(REQ_BITS)) u_prio (
    .req(req_q), .req_shift(req_shift)
  );

  cnvclk_div_core u_div (
    .clk(clk), .rst_n(rst_n), .req_shift(req_shift), .act_shift(act_shift),
    .cnt(cnt), .tc(tc), .conv_en(conv_en)
  );

  assign ratio_div16 = (act_shift == shift_t'(REQ_BITS));
  assign ratio_code  = status_code(act_shift);
endmodule

// File: rtl/cnvclk_prescaler_chk.sv
module cnvclk_prescaler_chk
  import cnvclk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                conv_en,
  input logic [1:0]          ratio_code,
  input logic                ratio_div16,
  input logic [REQ_BITS-1:0] req_q,
  input logic                wr_hit,
  input shift_t              req_shift,
  input shift_t              act_shift,
  input cnt_t                cnt,
  input logic                tc
);
  // R2
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:REQ_BITS] == '0);

  // R1
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> req_q == $past(bus_wdata[REQ_BITS-1:0]));

  // R5
  prio_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_shift == prio_shift(req_q));

  // R4
  passthru_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_shift == '0) |-> conv_en);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && act_shift != '0 && req_shift != '0) |=> !conv_en);

  // R7
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(act_shift));

  // R7
  status_moves_on_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ratio_div16, ratio_code}) |-> $past(conv_en));

  // R8
  status_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_div16 |-> ratio_code == 2'd0);

  // R9
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= period_last(act_shift));
endmodule

bind cnvclk_prescaler cnvclk_prescaler_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .conv_en(conv_en), .ratio_code(ratio_code), .ratio_div16(ratio_div16),
  .req_q(req_q), .wr_hit(wr_hit), .req_shift(req_shift),
  .act_shift(act_shift), .cnt(cnt), .tc(tc)
);

// File: tb/cnvclk_prescaler_tb_top.sv
`timescale 1ns/1ps
module cnvclk_prescaler_tb_top;
  localparam logic [11:0] RADDR = 12'hF76;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       conv_en;
  logic [1:0] ratio_code;
  logic       ratio_div16;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit live_chk = 0;

  // reference model state
  int m_div = 1;
  int m_phase = 0;
  logic [3:0] m_req = 4'h0;

  always #2.5 clk = ~clk;

  cnvclk_prescaler dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_en(conv_en), .ratio_code(ratio_code), .ratio_div16(ratio_div16)
  );

  function automatic int exp_div(input logic [3:0] r);
    int d = 1;
    for (int k = 0; k < 4; k++) if (r[k]) d = 2 << k;
    return d;
  endfunction

  function automatic int exp_code(input int d);
    return (d == 16) ? 0 : $clog2(d);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // model: period phase advances, new divisor taken at end of period
  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 1; m_phase = 0; m_req = 4'h0;
    end else begin
      if (m_phase == m_div - 1) begin
        m_phase = 0;
        m_div = exp_div(m_req);
      end else begin
        m_phase++;
      end
      if (bus_sel && bus_wr && bus_addr == RADDR) m_req = bus_wdata[3:0];
    end
  end

  // per-cycle comparison (R7, R9 on changes; R4, R6 steady; R8 status)
  always @(negedge clk) begin
    if (live_chk && !done) begin
      check("R7/R9 conv_en", int'(conv_en), int'(m_phase == m_div - 1));
      check("R8 ratio_code", int'(ratio_code), exp_code(m_div));
      check("R8 ratio_div16", int'(ratio_div16), int'(m_div == 16));
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    int gap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    check("R3 conv_en", int'(conv_en), 1);
    check("R3 ratio_code", int'(ratio_code), 0);
    check("R3 ratio_div16", int'(ratio_div16), 0);
    bus_read(RADDR, rd);
    check("R3 reg", int'(rd), 0);
    live_chk = 1;

    // R1 register access
    bus_write(RADDR, 8'h05);
    bus_read(RADDR, rd);
    check("R1 readback", int'(rd), 5);
    bus_read(12'hF77, rd);
    check("R1 other addr read", int'(rd), 0);
    bus_write(12'h076, 8'h0A);
    bus_read(RADDR, rd);
    check("R1 other addr write ignored", int'(rd), 5);
    // R2 reserved bits
    bus_write(RADDR, 8'hF3);
    bus_read(RADDR, rd);
    check("R2 reserved dropped", int'(rd), 3);
    bus_write(RADDR, 8'hA0);
    bus_read(RADDR, rd);
    check("R2 reserved only", int'(rd), 0);
    idle(20);

    // R5, R6, R4: pulse spacing for every request setting
    for (int c = 0; c < 16; c++) begin
      bus_write(RADDR, 8'(c));
      idle(40);
      while (!conv_en) @(negedge clk);
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
      end while (!conv_en);
      check($sformatf("R5/R6 spacing req=%0d", c), gap, exp_div(4'(c)));
    end

    // R7, R9: every ordered pair, second write at pair-dependent phase
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        bus_write(RADDR, 8'(a));
        idle(18 + ((a * 7 + b * 3) % 17));
        bus_write(RADDR, 8'(b));
        idle(34);
      end
    end

    // R7: write landing exactly on a terminal-count edge (/16 -> /2)
    bus_write(RADDR, 8'h08);
    idle(40);
    while (!conv_en) @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = RADDR; bus_wdata = 8'h01;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R7 old ratio kept after tc write", int'(ratio_div16), 1);
    idle(16);
    check("R7 new ratio after full period", int'(ratio_code), 1);
    idle(10);

    live_chk = 0;
    finish_run();
  end
endmodule